// File: doc/BRIEF.md
# ATM VC Merge Cell Serializer

The block lets several inbound ATM virtual circuits share one outbound virtual circuit without cells of different frames mixing on the wire. Each arriving cell carries its inbound VPI/VCI, an end-of-frame bit and an opaque 48-byte payload, all in one beat. A small match table, written through a configuration port, turns the inbound VPI/VCI into a table slot and an outbound VPI/VCI. Every slot has its own ring of cell storage.

Cells are held in their slot's ring until the cell that closes their frame has been stored. Only then does the frame become eligible for output. An arbiter picks one eligible slot at a frame boundary, in rotating order. The chosen frame is then sent cell after cell with the outbound header in place of the inbound one. No new choice is made until its last cell has left.

A frame too long for its ring is dropped whole. Cells that match no table slot are discarded. Each of these events has its own counter.

Top module: `cell_merge_serializer`

## Requirements
- R1: Each output cell carries the outbound VPI/VCI of the table slot whose valid inbound VPI/VCI matched the cell on entry. Its payload is passed through unchanged. Several slots may name the same outbound VPI/VCI.
- R2: No cell of a frame appears on the output until that frame's end-of-frame cell has been written into the ring. A partial frame is never released.
- R3: Once the first cell of a frame is accepted at the output, every following output beat belongs to the same frame until its end-of-frame cell. `out_first_o` is 1 on the first cell of each frame only.
- R4: When the output is free, the next frame comes from the first slot with a complete frame found by scanning upward, with wrap-around, starting at the slot after the one served last. After reset the scan starts at slot 0. While a frame is in progress no other slot is chosen.
- R5: A ring holds at most 16 cells. A cell that arrives for a full ring drops every stored cell of its frame and increments `overflow_cnt_o` once. The remaining cells of that frame, up to and including its end-of-frame cell, are discarded. A 16-cell frame that arrives into an empty ring is forwarded whole.
- R6: A cell that matches no valid table slot is discarded, never forwarded, and increments `unmapped_cnt_o`.
- R7: A configuration write to a slot discards any partial frame in that slot's ring. Complete frames already stored are kept.
- R8: While `out_valid_o` is 1 and `out_ready_i` is 0, the output cell is held unchanged. `in_ready_o` is 0 in any cycle that has a configuration write.
- R9: After reset no output is valid, both counters read zero, every table slot is invalid and `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input cell valid |
| in_ready_o | output | 1 | Input cell accepted |
| in_vpi_i | input | 12 | Inbound VPI |
| in_vci_i | input | 16 | Inbound VCI |
| in_eof_i | input | 1 | End-of-frame bit of the cell header |
| in_payload_i | input | 384 | Cell payload |
| out_valid_o | output | 1 | Output cell valid |
| out_ready_i | input | 1 | Downstream accepts output cell |
| out_first_o | output | 1 | First cell of a frame |
| out_vpi_o | output | 12 | Rewritten outbound VPI |
| out_vci_o | output | 16 | Rewritten outbound VCI |
| out_eof_o | output | 1 | End-of-frame bit |
| out_payload_o | output | 384 | Cell payload |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_idx_i | input | 2 | Table slot to write |
| cfg_valid_i | input | 1 | Slot valid bit |
| cfg_in_vpi_i | input | 12 | Inbound VPI to match |
| cfg_in_vci_i | input | 16 | Inbound VCI to match |
| cfg_out_vpi_i | input | 12 | Outbound VPI to insert |
| cfg_out_vci_i | input | 16 | Outbound VCI to insert |
| unmapped_cnt_o | output | 16 | Discarded unmatched cells |
| overflow_cnt_o | output | 16 | Frames dropped on ring overflow |

## Verification
The bench interleaves the cells of three frames from two circuits that merge onto one outbound VC, and stalls the output meanwhile. A design that releases partial frames, or that switches slots inside a frame, shows up as a wrong output order or as inbound headers left in place. Rotation is tested where it differs from plain index priority: after slot 1 is served, slot 2 must win over slot 0. After slot 2 is served, the scan must wrap back to slot 0. An 18-cell frame must vanish whole and bump the overflow counter once, while a 16-cell frame right after it must pass complete. An off-by-one in the full test or in the rollback breaks one of these two cases. A table rewrite in the middle of a frame must remove its stored cells, so only the final cell comes out, flagged as both first and last.

// File: rtl/cms_pkg.sv
package cms_pkg;
  localparam int VPI_W     = 12;
  localparam int VCI_W     = 16;
  localparam int PAYLOAD_W = 384;

  typedef struct packed {
    logic             vld;
    logic [VPI_W-1:0] in_vpi;
    logic [VCI_W-1:0] in_vci;
    logic [VPI_W-1:0] out_vpi;
    logic [VCI_W-1:0] out_vci;
  } map_entry_t;
endpackage

// File: rtl/cms_vc_table.sv
module cms_vc_table
  import cms_pkg::*;
#(
  parameter  int N_VC = 4,
  localparam int IdxW = $clog2(N_VC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [IdxW-1:0]  cfg_idx_i,
  input  map_entry_t       cfg_entry_i,
  input  logic [VPI_W-1:0] lk_vpi_i,
  input  logic [VCI_W-1:0] lk_vci_i,
  output logic             hit_o,
  output logic [IdxW-1:0]  hit_idx_o,
  input  logic [IdxW-1:0]  rd_idx_i,
  output logic [VPI_W-1:0] rd_vpi_o,
  output logic [VCI_W-1:0] rd_vci_o
);
  map_entry_t tbl_q [N_VC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_VC; i++) tbl_q[i] <= '0;
    end else if (cfg_we_i) begin
      tbl_q[cfg_idx_i] <= cfg_entry_i;
    end
  end

  // lowest matching slot wins
  always_comb begin
    hit_o     = 1'b0;
    hit_idx_o = '0;
    for (int i = N_VC - 1; i >= 0; i--) begin
      if (tbl_q[i].vld && tbl_q[i].in_vpi == lk_vpi_i && tbl_q[i].in_vci == lk_vci_i) begin
        hit_o     = 1'b1;
        hit_idx_o = IdxW'(i);
      end
    end
  end

  assign rd_vpi_o = tbl_q[rd_idx_i].out_vpi;
  assign rd_vci_o = tbl_q[rd_idx_i].out_vci;
endmodule

// File: rtl/cms_cell_buf.sv
module cms_cell_buf #(
  parameter  int DEPTH  = 16,
  parameter  int DATA_W = 384,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              wr_eof_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              flush_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_eof_o,
  output logic              frame_rdy_o,
  output logic              ovf_o
);
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  eof_q;
  logic [PW-1:0]     wr_q, cmt_q, rd_q, occ;
  logic              drop_q, full, store;

  assign occ         = wr_q - rd_q;
  assign full        = (occ == FULL);
  assign store       = wr_i && !drop_q && !full && !flush_i;
  assign ovf_o       = wr_i && !drop_q && full && !flush_i;
  assign frame_rdy_o = (rd_q != cmt_q);
  assign rd_data_o   = mem_q[rd_q[AW-1:0]];
  assign rd_eof_o    = eof_q[rd_q[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      cmt_q  <= '0;
      drop_q <= 1'b0;
    end else if (flush_i) begin
      wr_q   <= cmt_q;
      drop_q <= 1'b0;
    end else if (wr_i) begin
      if (drop_q) begin
        if (wr_eof_i) drop_q <= 1'b0;
      end else if (full) begin
        wr_q   <= cmt_q;
        drop_q <= !wr_eof_i;
      end else begin
        wr_q <= wr_q + 1'b1;
        if (wr_eof_i) cmt_q <= wr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else if (rd_i) rd_q <= rd_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (store) begin
      mem_q[wr_q[AW-1:0]] <= wr_data_i;
      eof_q[wr_q[AW-1:0]] <= wr_eof_i;
    end
  end

  // R2
  rd_committed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> frame_rdy_o);
  // R5
  occ_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= FULL);
  // R5
  ovf_rollback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (wr_q == cmt_q));
  // R7
  flush_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (wr_q == cmt_q) && !drop_q);
endmodule

// File: rtl/cms_rr_arb.sv
module cms_rr_arb #(
  parameter  int N    = 4,
  localparam int IdxW = $clog2(N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    req_i,
  input  logic            take_i,
  output logic            any_o,
  output logic [IdxW-1:0] gnt_o
);
  logic [IdxW-1:0] last_q;

  // scan from last+1 upward; nearest requester wins
  always_comb begin
    any_o = 1'b0;
    gnt_o = '0;
    for (int k = N; k >= 1; k--) begin
      int j;
      j = (int'(last_q) + k) % N;
      if (req_i[j]) begin
        any_o = 1'b1;
        gnt_o = IdxW'(j);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= IdxW'(N - 1);
    else if (take_i) last_q <= gnt_o;
  end

  // R4
  gnt_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> req_i[gnt_o]);
  // R4
  gnt_any_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> any_o);
endmodule

// File: rtl/cell_merge_serializer.sv
module cell_merge_serializer
  import cms_pkg::*;
#(
  parameter  int N_VC      = 4,
  parameter  int BUF_DEPTH = 16,
  parameter  int CNT_W     = 16,
  localparam int IdxW      = $clog2(N_VC)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [VPI_W-1:0]     in_vpi_i,
  input  logic [VCI_W-1:0]     in_vci_i,
  input  logic                 in_eof_i,
  input  logic [PAYLOAD_W-1:0] in_payload_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic                 out_first_o,
  output logic [VPI_W-1:0]     out_vpi_o,
  output logic [VCI_W-1:0]     out_vci_o,
  output logic                 out_eof_o,
  output logic [PAYLOAD_W-1:0] out_payload_o,
  input  logic                 cfg_we_i,
  input  logic [IdxW-1:0]      cfg_idx_i,
  input  logic                 cfg_valid_i,
  input  logic [VPI_W-1:0]     cfg_in_vpi_i,
  input  logic [VCI_W-1:0]     cfg_in_vci_i,
  input  logic [VPI_W-1:0]     cfg_out_vpi_i,
  input  logic [VCI_W-1:0]     cfg_out_vci_i,
  output logic [CNT_W-1:0]     unmapped_cnt_o,
  output logic [CNT_W-1:0]     overflow_cnt_o
);
  map_entry_t          cfg_entry;
  logic                hit, in_fire, out_fire, take, gnt_any;
  logic [IdxW-1:0]     hit_idx, gnt_idx, cur_q;
  logic                busy_q, first_q;
  logic [PAYLOAD_W-1:0] rd_data [N_VC];
  logic [N_VC-1:0]     rd_eof, frame_rdy, ovf;

  assign cfg_entry  = '{vld: cfg_valid_i, in_vpi: cfg_in_vpi_i, in_vci: cfg_in_vci_i,
                        out_vpi: cfg_out_vpi_i, out_vci: cfg_out_vci_i};
  assign in_ready_o = !cfg_we_i;
  assign in_fire    = in_valid_i && in_ready_o;

  cms_vc_table #(.N_VC(N_VC)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_idx_i  (cfg_idx_i),
    .cfg_entry_i(cfg_entry),
    .lk_vpi_i   (in_vpi_i),
    .lk_vci_i   (in_vci_i),
    .hit_o      (hit),
    .hit_idx_o  (hit_idx),
    .rd_idx_i   (cur_q),
    .rd_vpi_o   (out_vpi_o),
    .rd_vci_o   (out_vci_o)
  );

  for (genvar g = 0; g < N_VC; g++) begin : g_buf
    cms_cell_buf #(.DEPTH(BUF_DEPTH), .DATA_W(PAYLOAD_W)) u_buf (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (in_fire && hit && hit_idx == IdxW'(g)),
      .wr_eof_i   (in_eof_i),
      .wr_data_i  (in_payload_i),
      .flush_i    (cfg_we_i && cfg_idx_i == IdxW'(g)),
      .rd_i       (out_fire && cur_q == IdxW'(g)),
      .rd_data_o  (rd_data[g]),
      .rd_eof_o   (rd_eof[g]),
      .frame_rdy_o(frame_rdy[g]),
      .ovf_o      (ovf[g])
    );
  end

  cms_rr_arb #(.N(N_VC)) u_arb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (frame_rdy),
    .take_i(take),
    .any_o (gnt_any),
    .gnt_o (gnt_idx)
  );

  assign take          = !busy_q && gnt_any;
  assign out_valid_o   = busy_q;
  assign out_fire      = busy_q && out_ready_i;
  assign out_first_o   = first_q;
  assign out_eof_o     = rd_eof[cur_q];
  assign out_payload_o = rd_data[cur_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      first_q <= 1'b0;
      cur_q   <= '0;
    end else if (take) begin
      busy_q  <= 1'b1;
      first_q <= 1'b1;
      cur_q   <= gnt_idx;
    end else if (out_fire) begin
      first_q <= 1'b0;
      if (out_eof_o) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unmapped_cnt_o <= '0;
      overflow_cnt_o <= '0;
    end else begin
      if (in_fire && !hit) unmapped_cnt_o <= unmapped_cnt_o + 1'b1;
      if (|ovf) overflow_cnt_o <= overflow_cnt_o + 1'b1;
    end
  end

  // R3
  frame_atomic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && !out_eof_o) |=> (out_valid_o && !out_first_o));
  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_payload_o)
                                       && $stable(out_eof_o) && $stable(out_first_o)));
  // R6
  unmapped_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_fire && !hit) |=> (unmapped_cnt_o == CNT_W'($past(unmapped_cnt_o) + 1'b1)));
  // R5
  single_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ovf));
endmodule

// File: tb/cell_merge_serializer_bench.sv
module cell_merge_serializer_bench;
  localparam int PW = cms_pkg::PAYLOAD_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          in_valid = 1'b0, in_eof = 1'b0, in_ready;
  logic [11:0]   in_vpi = '0;
  logic [15:0]   in_vci = '0;
  logic [PW-1:0] in_payload = '0;
  logic          out_valid, out_first, out_eof;
  logic          out_ready = 1'b0;
  logic [11:0]   out_vpi;
  logic [15:0]   out_vci;
  logic [PW-1:0] out_payload;
  logic          cfg_we = 1'b0, cfg_valid = 1'b0;
  logic [1:0]    cfg_idx = '0;
  logic [11:0]   cfg_in_vpi = '0, cfg_out_vpi = '0;
  logic [15:0]   cfg_in_vci = '0, cfg_out_vci = '0;
  logic [15:0]   unmapped_cnt, overflow_cnt;

  cell_merge_serializer u_cell_merge_serializer (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_vpi_i(in_vpi), .in_vci_i(in_vci),
    .in_eof_i(in_eof), .in_payload_i(in_payload),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_first_o(out_first),
    .out_vpi_o(out_vpi), .out_vci_o(out_vci), .out_eof_o(out_eof), .out_payload_o(out_payload),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_valid_i(cfg_valid),
    .cfg_in_vpi_i(cfg_in_vpi), .cfg_in_vci_i(cfg_in_vci),
    .cfg_out_vpi_i(cfg_out_vpi), .cfg_out_vci_i(cfg_out_vci),
    .unmapped_cnt_o(unmapped_cnt), .overflow_cnt_o(overflow_cnt)
  );

  // stimulus: kind[38:37] 0=cell 1=drain 2=expect idle 3=expect held cell
  //           vpi[36:25] vci[24:9] eof/first[8] tag[7:0]
  localparam int NV = 15;
  localparam logic [38:0] VEC [NV] = '{
    {2'd0, 12'd1, 16'd100, 1'b0, 8'h10},
    {2'd0, 12'd1, 16'd101, 1'b0, 8'h20},
    {2'd0, 12'd1, 16'd100, 1'b0, 8'h11},
    {2'd2, 12'd0, 16'd0,   1'b0, 8'h00},
    {2'd0, 12'd1, 16'd101, 1'b1, 8'h21},
    {2'd0, 12'd1, 16'd100, 1'b1, 8'h12},
    {2'd0, 12'd2, 16'd200, 1'b1, 8'h30},
    {2'd3, 12'd0, 16'd500, 1'b1, 8'h20},
    {2'd0, 12'd3, 16'd300, 1'b1, 8'h99},
    {2'd3, 12'd0, 16'd500, 1'b1, 8'h20},
    {2'd1, 12'd0, 16'd0,   1'b0, 8'h00},
    {2'd0, 12'd2, 16'd200, 1'b1, 8'h33},
    {2'd0, 12'd1, 16'd100, 1'b1, 8'h13},
    {2'd0, 12'd1, 16'd101, 1'b1, 8'h22},
    {2'd1, 12'd0, 16'd0,   1'b0, 8'h00}
  };
  // expected output: vpi vci eof first tag
  localparam int NE = 9;
  localparam logic [37:0] EXP [NE] = '{
    {12'd5, 16'd500, 1'b0, 1'b1, 8'h20},
    {12'd5, 16'd500, 1'b1, 1'b0, 8'h21},
    {12'd6, 16'd600, 1'b1, 1'b1, 8'h30},
    {12'd5, 16'd500, 1'b0, 1'b1, 8'h10},
    {12'd5, 16'd500, 1'b0, 1'b0, 8'h11},
    {12'd5, 16'd500, 1'b1, 1'b0, 8'h12},
    {12'd6, 16'd600, 1'b1, 1'b1, 8'h33},
    {12'd5, 16'd500, 1'b1, 1'b1, 8'h13},
    {12'd5, 16'd500, 1'b1, 1'b1, 8'h22}
  };

  int checks = 0, fails = 0;
  int mon_checks = 0, mon_fails = 0;
  int cap_n = 0;
  logic [37:0] cap [256];
  bit done = 1'b0;

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && cap_n < 256) begin
      cap[cap_n] = {out_vpi, out_vci, out_eof, out_first, out_payload[7:0]};
      cap_n++;
      mon_checks++;
      if (out_payload != {48{out_payload[7:0]}}) begin
        mon_fails++;
        $display("FAIL R1 payload altered: actual %h expected %h", out_payload[63:0],
                 {8{out_payload[7:0]}});
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_cell(input logic [11:0] vpi, input logic [15:0] vci,
                           input logic eof, input logic [7:0] tag);
    @(posedge clk); #1;
    in_valid = 1'b1; in_vpi = vpi; in_vci = vci; in_eof = eof;
    in_payload = {48{tag}};
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic cfg_write(input logic [1:0] idx, input logic [11:0] ivpi,
                           input logic [15:0] ivci, input logic [11:0] ovpi,
                           input logic [15:0] ovci);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_idx = idx; cfg_valid = 1'b1;
    cfg_in_vpi = ivpi; cfg_in_vci = ivci; cfg_out_vpi = ovpi; cfg_out_vci = ovci;
    @(negedge clk);
    // R8: input blocked during a table write
    chk(in_ready == 1'b0, "R8", "in_ready during cfg write", 64'(in_ready), 64'd0);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==",
               checks + mon_checks, fails + mon_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(out_valid == 1'b0, "R9", "out_valid after reset", 64'(out_valid), 64'd0);
    chk(unmapped_cnt == 0 && overflow_cnt == 0, "R9", "counters after reset",
        {unmapped_cnt, overflow_cnt}, 64'd0);
    chk(in_ready == 1'b1, "R9", "in_ready after reset", 64'(in_ready), 64'd1);

    // R1: slots 0 and 1 merge onto VPI/VCI 5/500, slot 2 goes to 6/600
    cfg_write(2'd0, 12'd1, 16'd100, 12'd5, 16'd500);
    cfg_write(2'd1, 12'd1, 16'd101, 12'd5, 16'd500);
    cfg_write(2'd2, 12'd2, 16'd200, 12'd6, 16'd600);

    for (int v = 0; v < NV; v++) begin
      logic [38:0] e;
      e = VEC[v];
      case (e[38:37])
        2'd0: send_cell(e[36:25], e[24:9], e[8], e[7:0]);
        2'd1: begin
          @(posedge clk); #1 out_ready = 1'b1;
          repeat (40) @(posedge clk);
          #1 out_ready = 1'b0;
        end
        2'd2: begin
          @(negedge clk);
          // R2 nothing leaves before a frame is closed
          chk(out_valid == 1'b0, "R2", "output before any end-of-frame", 64'(out_valid), 64'd0);
        end
        default: begin
          @(negedge clk);
          // R8 stalled cell held
          chk(out_valid && out_vci == e[24:9] && out_payload[7:0] == e[7:0] && out_first == e[8],
              "R8", "held output cell", {out_valid, out_first, out_vci, out_payload[7:0]},
              {1'b1, e[8], e[24:9], e[7:0]});
        end
      endcase
    end

    chk(cap_n == NE, "R6", "output cell count", 64'(cap_n), 64'(NE));
    for (int i = 0; i < NE; i++) begin
      // R1 R3 R4: header, frame order and rotation
      chk(cap[i] == EXP[i], "R4", $sformatf("output cell %0d", i), 64'(cap[i]), 64'(EXP[i]));
    end
    chk(unmapped_cnt == 16'd1, "R6", "unmapped counter", 64'(unmapped_cnt), 64'd1);
    chk(overflow_cnt == 16'd0, "R5", "overflow counter idle", 64'(overflow_cnt), 64'd0);

    // R5: overflow drops whole frame, then an exact-fit frame passes
    cfg_write(2'd3, 12'd4, 16'd400, 12'd7, 16'd700);
    out_ready = 1'b1;
    base = cap_n;
    for (int i = 0; i < 18; i++) send_cell(12'd4, 16'd400, i == 17, 8'(8'h60 + i));
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(overflow_cnt == 16'd1, "R5", "overflow counter", 64'(overflow_cnt), 64'd1);
    chk(cap_n == base, "R5", "cells from overflowed frame", 64'(cap_n), 64'(base));
    for (int i = 0; i < 16; i++) send_cell(12'd4, 16'd400, i == 15, 8'(8'h40 + i));
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(cap_n == base + 16, "R5", "16-cell frame length", 64'(cap_n), 64'(base + 16));
    chk(cap[base] == {12'd7, 16'd700, 1'b0, 1'b1, 8'h40}, "R5", "16-cell frame head",
        64'(cap[base]), 64'({12'd7, 16'd700, 1'b0, 1'b1, 8'h40}));
    chk(cap[base+15] == {12'd7, 16'd700, 1'b1, 1'b0, 8'h4F}, "R5", "16-cell frame tail",
        64'(cap[base+15]), 64'({12'd7, 16'd700, 1'b1, 1'b0, 8'h4F}));

    // R7: table write flushes partial frame
    base = cap_n;
    send_cell(12'd1, 16'd100, 1'b0, 8'h50);
    send_cell(12'd1, 16'd100, 1'b0, 8'h51);
    cfg_write(2'd0, 12'd1, 16'd100, 12'd5, 16'd500);
    send_cell(12'd1, 16'd100, 1'b1, 8'h55);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(cap_n == base + 1, "R7", "cells after flush", 64'(cap_n), 64'(base + 1));
    chk(cap[base] == {12'd5, 16'd500, 1'b1, 1'b1, 8'h55}, "R7", "surviving cell",
        64'(cap[base]), 64'({12'd5, 16'd500, 1'b1, 1'b1, 8'h55}));
    chk(unmapped_cnt == 16'd1, "R6", "unmapped counter unchanged", 64'(unmapped_cnt), 64'd1);

    finish_run();
  end
endmodule